// File: doc/BRIEF.md
# Host Receive Byte Port

This block carries a 24-bit word from the core to an external host. The core writes the word into a one-entry transmit register. As soon as the host side is free, the word moves into three byte registers that the host reads one at a time: high, middle, then low. A receive-full flag records that a word is waiting. The host can poll the flag in bit 0 of an 8-bit status register. The flag can also pull an active-low request pin so that the host is told without polling.

The host frees the port by reading the low byte, which is the last byte it reads. It can also drop the flag with an initialize pulse. Four other conditions empty the whole path: the system reset, a software reset, a reset of this interface only, and the stop mode. The status register cannot be written: host writes to any address of the block are ignored, so software may step through every address safely.

Top module: `host_rx_port`

## Requirements
- R1: After reset the receive-full flag is 0, the transmit register is empty (`core_tx_empty` = 1), `host_req_n` is 1 and every address reads 0.
- R2: A core write is accepted only while the transmit register is empty. It marks the register full (`core_tx_empty` = 0). A core write while the register is full is ignored.
- R3: When the transmit register is full and the receive-full flag is clear, the word moves into the byte registers at the next clock edge. At that edge the flag becomes 1 and the transmit register becomes empty. Address 1 then reads bits 23:16, address 2 reads bits 15:8 and address 3 reads bits 7:0.
- R4: A host read of address 1 or address 2 leaves the receive-full flag unchanged.
- R5: A host read of address 3 (the low byte, with `host_sel`=1 and `host_wr`=0) clears the flag at the next edge. A word waiting in the transmit register moves across one edge after that.
- R6: While the flag is 1, the byte registers keep their value and a waiting word stays in the transmit register.
- R7: A host write (`host_sel`=1, `host_wr`=1) to any address changes no state.
- R8: `host_init` clears the flag at the next edge. It also blocks a transfer due in the same cycle, so that transfer takes place one edge later.
- R9: `sw_rst`, `if_rst` and `stop_mode` each clear the flag and empty the transmit register at the next edge. A core write in that cycle is dropped.
- R10: `host_req_n` is 0 exactly when `req_enable` is 1 and the flag is 1. Status bit 0 shows the flag whatever the value of `req_enable`.
- R11: Status bits 7:1 read 0, and addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| core_wr | input | 1 | Core write strobe for the transmit register |
| core_wdata | input | 24 | Word written by the core |
| core_tx_empty | output | 1 | Transmit register empty |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host access is a write (1) or a read (0) |
| host_addr | input | 3 | Host address: 0 status, 1 high byte, 2 middle byte, 3 low byte |
| host_rdata | output | 8 | Contents of the addressed register |
| host_init | input | 1 | Host initialize pulse, clears the receive-full flag |
| req_enable | input | 1 | Lets the receive-full flag drive the request pin |
| sw_rst | input | 1 | Software reset |
| if_rst | input | 1 | Reset of this interface only |
| stop_mode | input | 1 | Stop mode, empties the path |
| host_req_n | output | 1 | Active-low host request |

## Verification
Two pairs of events can meet in one clock cycle. The first pair is a transfer that has become due and an initialize pulse. The bench loads a word with the port free and raises `host_init` in the cycle in which the transfer would fire. It then expects the flag to read 0 for one cycle, with the word still held in the transmit register, and to read 1 one cycle later. The second pair is a low-byte read and a waiting word. Here the bench expects one cycle with the flag at 0, after which the new word appears. Random stimulus also lets both pairs meet, and each cycle the outputs are compared with a bench reference model.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

  localparam int HRX_STATUS_ADDR = 0;

  typedef enum logic [1:0] {
    FOP_HOLD  = 2'd0,
    FOP_SET   = 2'd1,
    FOP_CLEAR = 2'd2
  } flag_op_e;

endpackage

// File: rtl/hrx_txreg.sv
module hrx_txreg #(
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] wdata,
  input  logic          take,
  input  logic          flush,
  output logic          full,
  output logic [WW-1:0] data
);

  logic          full_q, full_d;
  logic [WW-1:0] data_q;
  logic          data_en;

  always_comb begin
    full_d = full_q;
    if (flush || take) begin
      full_d = 1'b0;
    end else if (load) begin
      full_d = 1'b1;
    end
  end

  assign data_en = load && !flush && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= wdata;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/hrx_rxbank.sv
module hrx_rxbank #(
  parameter int NB = 3,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NB*BW-1:0] word_in,
  output logic [NB*BW-1:0] word_o
);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BW-1:0] q;
    logic [BW-1:0] d;

    assign d = word_in[g*BW +: BW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (load) begin
        q <= d;
      end
    end

    assign word_o[g*BW +: BW] = q;
  end

endmodule

// File: rtl/hrx_flag.sv
module hrx_flag
  import hrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_read,
  input  logic clr_force,
  output logic full
);

  flag_op_e op;
  logic     full_q, full_d;

  always_comb begin
    op = FOP_HOLD;
    if (clr_force) begin
      op = FOP_CLEAR;
    end else if (set) begin
      op = FOP_SET;
    end else if (clr_read) begin
      op = FOP_CLEAR;
    end
  end

  always_comb begin
    case (op)
      FOP_SET:   full_d = 1'b1;
      FOP_CLEAR: full_d = 1'b0;
      default:   full_d = full_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  assign full = full_q;

endmodule

// File: rtl/hrx_hostif.sv
module hrx_hostif
  import hrx_pkg::*;
#(
  parameter int NB = 3,
  parameter int BW = 8,
  parameter int AW = 3
) (
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic             rx_full,
  input  logic [NB*BW-1:0] rx_word,
  output logic             rd_last,
  output logic [BW-1:0]    rdata
);

  localparam logic [AW-1:0] LAST_ADDR   = AW'(NB);
  localparam logic [AW-1:0] STATUS_ADDR = AW'(HRX_STATUS_ADDR);

  assign rd_last = host_sel && !host_wr && (host_addr == LAST_ADDR);

  always_comb begin
    rdata = '0;
    if (host_addr == STATUS_ADDR) begin
      rdata[0] = rx_full;
    end
    for (int i = 0; i < NB; i++) begin
      if (host_addr == AW'(i + 1)) begin
        rdata = rx_word[(NB-1-i)*BW +: BW];
      end
    end
  end

endmodule

// File: rtl/host_rx_port.sv
module host_rx_port #(
  parameter int NB = 3,
  parameter int BW = 8,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_wr,
  input  logic [NB*BW-1:0] core_wdata,
  output logic             core_tx_empty,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  output logic [BW-1:0]    host_rdata,
  input  logic             host_init,
  input  logic             req_enable,
  input  logic             sw_rst,
  input  logic             if_rst,
  input  logic             stop_mode,
  output logic             host_req_n
);

  localparam int WW = NB * BW;

  logic [1:0]    rst_q;
  logic          rst_sn;
  logic          soft_clr;
  logic          tx_full;
  logic [WW-1:0] tx_word;
  logic          rx_full;
  logic [WW-1:0] rx_word;
  logic          rd_last;
  logic          xfer;
  logic          tx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_q[1];

  assign soft_clr = sw_rst || if_rst || stop_mode;
  assign xfer     = tx_full && !rx_full && !host_init && !soft_clr;
  assign tx_load  = core_wr && !tx_full && !soft_clr;

  hrx_txreg #(.WW(WW)) u_tx (
    .clk   (clk),
    .rst_n (rst_sn),
    .load  (tx_load),
    .wdata (core_wdata),
    .take  (xfer),
    .flush (soft_clr),
    .full  (tx_full),
    .data  (tx_word)
  );

  hrx_rxbank #(.NB(NB), .BW(BW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load    (xfer),
    .word_in (tx_word),
    .word_o  (rx_word)
  );

  hrx_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_sn),
    .set       (xfer),
    .clr_read  (rd_last),
    .clr_force (host_init || soft_clr),
    .full      (rx_full)
  );

  hrx_hostif #(.NB(NB), .BW(BW), .AW(AW)) u_host (
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .rx_full   (rx_full),
    .rx_word   (rx_word),
    .rd_last   (rd_last),
    .rdata     (host_rdata)
  );

  assign core_tx_empty = !tx_full;
  assign host_req_n    = !(req_enable && rx_full);

endmodule

// File: rtl/hrx_checker.sv
module hrx_checker #(
  parameter int NB = 3,
  parameter int BW = 8,
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_full,
  input logic [NB*BW-1:0] rx_word,
  input logic             core_tx_empty,
  input logic             host_sel,
  input logic             host_wr,
  input logic [AW-1:0]    host_addr,
  input logic             host_init,
  input logic             soft_clr,
  input logic             host_req_n
);

  logic upper_rd;
  logic low_rd;

  assign upper_rd = host_sel && !host_wr && (host_addr != '0) && (host_addr < AW'(NB));
  assign low_rd   = host_sel && !host_wr && (host_addr == AW'(NB));

  AST_XFER_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> core_tx_empty && $past(!core_tx_empty)); // R3

  AST_UPPER_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    upper_rd && rx_full && !host_init && !soft_clr |=> rx_full); // R4

  AST_LOW_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd && rx_full |=> !rx_full); // R5

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_word)); // R6

  AST_WAITING_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !core_tx_empty && rx_full && !soft_clr |=> !core_tx_empty); // R6

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_init |=> !rx_full); // R8

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !rx_full && core_tx_empty); // R9

  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_full |-> host_req_n); // R10

endmodule

bind host_rx_port hrx_checker #(.NB(NB), .BW(BW), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sn),
  .rx_full       (rx_full),
  .rx_word       (rx_word),
  .core_tx_empty (core_tx_empty),
  .host_sel      (host_sel),
  .host_wr       (host_wr),
  .host_addr     (host_addr),
  .host_init     (host_init),
  .soft_clr      (sw_rst || if_rst || stop_mode),
  .host_req_n    (host_req_n)
);

// File: tb/tb_host_rx_port.sv
`timescale 1ns/1ps
module tb_host_rx_port;

  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_wr;
  logic [23:0] core_wdata;
  logic        core_tx_empty;
  logic        host_sel;
  logic        host_wr;
  logic [2:0]  host_addr;
  logic [7:0]  host_rdata;
  logic        host_init;
  logic        req_enable;
  logic        sw_rst;
  logic        if_rst;
  logic        stop_mode;
  logic        host_req_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference model state
  logic        m_txf;
  logic [23:0] m_txd;
  logic        m_rxf;
  logic [23:0] m_rxw;

  always #(CLK_NS/2) clk = ~clk;

  host_rx_port dut (
    .clk(clk), .rst_n(rst_n),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_tx_empty(core_tx_empty),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_rdata(host_rdata), .host_init(host_init), .req_enable(req_enable),
    .sw_rst(sw_rst), .if_rst(if_rst), .stop_mode(stop_mode),
    .host_req_n(host_req_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0:    exp_read = {7'b0, m_rxf};
      3'd1:    exp_read = m_rxw[23:16];
      3'd2:    exp_read = m_rxw[15:8];
      3'd3:    exp_read = m_rxw[7:0];
      default: exp_read = 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    if (a == 3'd0)      read_tag = "R10";
    else if (a <= 3'd3) read_tag = "R3";
    else                read_tag = "R11";
  endfunction

  task automatic model_step();
    logic clr, force_clr, xf, lowrd;
    clr       = sw_rst | if_rst | stop_mode;
    force_clr = clr | host_init;
    xf        = m_txf & ~m_rxf & ~force_clr;
    lowrd     = host_sel & ~host_wr & (host_addr == 3'd3);
    if (xf) m_rxw = m_txd;
    if (force_clr)  m_rxf = 1'b0;
    else if (xf)    m_rxf = 1'b1;
    else if (lowrd) m_rxf = 1'b0;
    if (clr || xf) m_txf = 1'b0;
    else if (core_wr && !m_txf) begin
      m_txf = 1'b1;
      m_txd = core_wdata;
    end
  endtask

  // One clock cycle: check registered outputs, apply inputs, check read data, advance.
  task automatic cyc(input string tag, input logic cw, input logic [23:0] cd,
                     input logic s, input logic w, input logic [2:0] a,
                     input logic ini, input logic rq, input logic sr,
                     input logic ir, input logic sm);
    string t;
    @(negedge clk);
    chk((tag == "") ? "R2" : tag, "core_tx_empty", core_tx_empty, !m_txf);
    chk((tag == "") ? "R10" : tag, "host_req_n", host_req_n, !(req_enable & m_rxf));
    core_wr = cw; core_wdata = cd; host_sel = s; host_wr = w; host_addr = a;
    host_init = ini; req_enable = rq; sw_rst = sr; if_rst = ir; stop_mode = sm;
    #1;
    t = (tag == "") ? read_tag(a) : tag;
    chk(t, "host_rdata", host_rdata, exp_read(a));
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(input string tag, input logic rq);
    cyc(tag, 0, 24'h0, 0, 0, 3'd0, 0, rq, 0, 0, 0);
  endtask

  task automatic hread(input string tag, input logic [2:0] a, input logic rq);
    cyc(tag, 0, 24'h0, 1, 0, a, 0, rq, 0, 0, 0);
  endtask

  task automatic cwrite(input string tag, input logic [23:0] d, input logic rq);
    cyc(tag, 1, d, 0, 0, 3'd0, 0, rq, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    m_txf = 0; m_txd = '0; m_rxf = 0; m_rxw = '0;
    rst_n = 0; core_wr = 0; core_wdata = '0; host_sel = 0; host_wr = 0;
    host_addr = '0; host_init = 0; req_enable = 0; sw_rst = 0; if_rst = 0; stop_mode = 0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1;

    // R1: reset state, all addresses zero
    for (int a = 0; a < 8; a++) hread("R1", 3'(a), 1);
    idle("R1", 1);

    // R2/R3: load then transfer, byte placement
    cwrite("R2", 24'hA1B2C3, 1);
    idle("R3", 1);
    chk("R3", "status bit", {7'b0, m_rxf}, 8'h01);
    // R4: upper reads keep the flag
    hread("R4", 3'd1, 1);
    hread("R4", 3'd2, 1);
    hread("R4", 3'd0, 1);
    // R6: waiting word while full, second write ignored (R2)
    cwrite("R6", 24'h112233, 1);
    cwrite("R2", 24'hDEAD00, 1);
    idle("R6", 1);
    hread("R6", 3'd3, 1);          // R5: low read clears
    idle("R5", 1);                 // flag 0 here, transfer at this edge
    hread("R5", 3'd1, 1);
    hread("R5", 3'd3, 1);
    idle("R5", 0);

    // R7: host writes to every address ignored
    cwrite("R7", 24'h0F1E2D, 0);
    idle("R7", 0);
    for (int a = 0; a < 8; a++) cyc("R7", 0, 24'h0, 1, 1, 3'(a), 0, 0, 0, 0, 0);
    for (int a = 0; a < 4; a++) hread("R7", 3'(a), 0);
    // R10: request pin with enable off, then on
    idle("R10", 0);
    idle("R10", 1);
    idle("R10", 1);

    // R8: init meets a due transfer
    hread("R8", 3'd3, 1);
    cwrite("R8", 24'h778899, 1);   // loaded at this edge, transfer due next
    cyc("R8", 0, 24'h0, 0, 0, 3'd0, 1, 1, 0, 0, 0);
    chk("R8", "flag after init", {7'b0, m_rxf}, 8'h00);
    idle("R8", 1);                 // transfer now
    hread("R8", 3'd2, 1);

    // R9: each clear source, with a word waiting and a core write
    cwrite("R9", 24'h123456, 1);
    cyc("R9", 1, 24'h654321, 0, 0, 3'd0, 0, 1, 1, 0, 0);
    idle("R9", 1);
    cwrite("R9", 24'hCAFE01, 1);
    idle("R9", 1);
    cwrite("R9", 24'hCAFE02, 1);
    cyc("R9", 0, 24'h0, 0, 0, 3'd0, 0, 1, 0, 1, 0);
    idle("R9", 1);
    cwrite("R9", 24'hCAFE03, 1);
    idle("R9", 1);
    cyc("R9", 0, 24'h0, 0, 0, 3'd0, 0, 1, 0, 0, 1);
    hread("R9", 3'd0, 1);
    hread("R11", 3'd5, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic cw, s, w, ini, rq, sr, ir, sm;
      logic [2:0] a;
      cw  = ($urandom % 100) < 35;
      s   = ($urandom % 100) < 55;
      w   = ($urandom % 100) < 20;
      a   = (($urandom % 100) < 30) ? 3'd3 : 3'($urandom % 8);
      ini = ($urandom % 100) < 3;
      rq  = ((i / 50) % 2) == 0;
      sr  = ($urandom % 200) == 0;
      ir  = ($urandom % 200) == 0;
      sm  = ($urandom % 200) == 0;
      cyc("", cw, 24'($urandom), s, w, a, ini, rq, sr, ir, sm);
    end
    idle("", 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule